// File: doc/BRIEF.md
# Disk Controller Host Phase Sequencer

This block is the host-facing sequencer of a floppy-style disk controller. A host moves every byte through a single data register: it writes the bytes of a command, may then move a block of execution data itself (polled mode), and finally reads back result bytes. The sequencer walks the command, execution and result phases for each command. It sizes each phase from a small opcode table, and it drives a read-only main status byte. That byte tells the host whether it may touch the data register, in which direction, whether a command is in flight, whether a polled execution phase is in progress, and which drives are still seeking.

Seek and recalibrate start a per-drive busy flag when their last byte is taken. The flag is cleared by an external seek-complete strobe for that drive. These flags are independent of the command machine, so seeks on both drives may overlap, and new commands may run while they are pending. In DMA mode the execution phase is closed by an external done strobe, and the host is locked out until the strobe arrives.

Top module: `dskc_phase_seq`

## Requirements
- R1: After reset the status byte reads 0x80: the request bit (bit 7) is 1, the direction bit (bit 6) is 0 (host writes), and the busy, polled-execution and drive-busy bits are 0.
- R2: Opcodes are matched on bits 4:0; bits 7:5 are ignored. The command byte counts are 0x03 (mode set) 3, 0x07 (recalibrate) 2, 0x0F (seek) 3, 0x04 (drive status) 2, 0x08 (interrupt status) 1, 0x06 (read) 9, and 0x05 (write) 9. Command busy (bit 4) rises once the first command byte is accepted. For 0x03, 0x07 and 0x0F, which have no result bytes, it falls right after the last command byte.
- R3: In the result phase, bits 7, 6 and 4 are 1. Result byte 0 is the drive number taken from bit 0 of command byte 1 (0 if the command has one byte). Result byte k≥1 is the opcode byte plus k, modulo 256. Result counts are 0x04 one, 0x08 two, and 0x05/0x06 seven. Busy clears after the last result byte is read.
- R4: After every accepted data-register access, the request bit is 0 for exactly one clock and then returns with the direction of the next byte.
- R5: Bit 0 of the third byte of opcode 0x03 selects polled mode (1) or DMA mode (0). In polled mode, the execution phase of 0x06/0x05 sets bit 5 with the request bit 1 and direction 1 (0x06) or 0 (0x05). That phase lasts EXEC_LEN host transfers, and reads in it return the media_rdata input.
- R6: In DMA mode the execution phase shows the request bit 0 and bit 5 0. One exec_done pulse moves it to the result phase.
- R7: Seek and recalibrate set the busy bit of the drive named in bit 0 of command byte 1 when their last byte is accepted. seek_done[d] clears drive d's bit. Both drive bits can be set at once, and neither affects command busy.
- R8: An opcode outside the table takes one command byte and yields a one-byte result phase returning 0x80.
- R9: Status bits 3 and 2 always read 0.
- R10: A write while the direction bit is 1, a read while it is 0, and any access while the request bit is 0 are ignored: the phase, the byte position and the request bit are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | One-cycle data-register write strobe |
| host_rd | input | 1 | One-cycle data-register read strobe |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Byte returned to the host on a read |
| status | output | 8 | Main status byte |
| media_rdata | input | 8 | Execution-phase byte supplied for polled reads |
| exec_done | input | 1 | Ends a DMA-mode execution phase |
| seek_done | input | NUM_DRV | Per-drive seek-complete strobes |

## Verification
The bench targets the edges between phases. It checks a one-byte command that jumps straight to results, an unknown opcode, and the last command byte of a no-result command. A design that is off by one at any of these edges would leave busy stuck at 1 or demand an extra byte. It runs a polled read and a polled write and checks both direction bits. A swapped direction would let the host read during a write phase. It then runs a DMA phase that must stay locked until exec_done. Overlapped seeks on both drives, with completions in a different order from the starts, catch a shared or cross-wired busy flag. Reads in the wrong direction are checked to leave the status and the result byte unchanged.

// File: rtl/dskc_pkg.sv
package dskc_pkg;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_EXEC = 2'd1,
    PH_RES  = 2'd2
  } phase_e;

  // Per-opcode shape of a command
  typedef struct packed {
    logic       known;
    logic [3:0] cmd_len;
    logic       has_exec;
    logic       exec_to_host;
    logic [2:0] res_len;
    logic       starts_seek;
    logic       sets_mode;
  } op_info_t;

  localparam logic [7:0] BAD_OP_CODE = 8'h80;

endpackage

// File: rtl/dskc_rst_sync.sv
module dskc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;
endmodule

// File: rtl/dskc_op_decode.sv
module dskc_op_decode
  import dskc_pkg::*;
(
  input  logic [7:0] op_byte,
  output op_info_t   info
);
  always_comb begin
    info = '0;
    info.known = 1'b1;
    unique case (op_byte[4:0])
      5'h03: begin info.cmd_len = 4'd3; info.sets_mode = 1'b1; end
      5'h07: begin info.cmd_len = 4'd2; info.starts_seek = 1'b1; end
      5'h0F: begin info.cmd_len = 4'd3; info.starts_seek = 1'b1; end
      5'h04: begin info.cmd_len = 4'd2; info.res_len = 3'd1; end
      5'h08: begin info.cmd_len = 4'd1; info.res_len = 3'd2; end
      5'h06: begin
        info.cmd_len = 4'd9; info.has_exec = 1'b1;
        info.exec_to_host = 1'b1; info.res_len = 3'd7;
      end
      5'h05: begin
        info.cmd_len = 4'd9; info.has_exec = 1'b1;
        info.exec_to_host = 1'b0; info.res_len = 3'd7;
      end
      default: begin
        info.known   = 1'b0;
        info.cmd_len = 4'd1;
        info.res_len = 3'd1;
      end
    endcase
  end
endmodule

// File: rtl/dskc_drv_busy.sv
module dskc_drv_busy #(
  parameter int NUM_DRV = 2,
  localparam int DRV_W = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               seek_go,
  input  logic [DRV_W-1:0]   seek_drv,
  input  logic [NUM_DRV-1:0] seek_done,
  output logic [NUM_DRV-1:0] drv_busy
);
  for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
    logic set_d;
    logic busy_q;
    logic busy_d;
    logic en;

    assign set_d = seek_go && (seek_drv == DRV_W'(d));
    assign en    = set_d || seek_done[d];

    always_comb begin
      busy_d = busy_q;
      if (set_d)             busy_d = 1'b1;
      else if (seek_done[d]) busy_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  busy_q <= 1'b0;
      else if (en) busy_q <= busy_d;
    end

    assign drv_busy[d] = busy_q;
  end
endmodule

// File: rtl/dskc_phase_fsm.sv
module dskc_phase_fsm
  import dskc_pkg::*;
#(
  parameter int NUM_DRV  = 2,
  parameter int EXEC_LEN = 4,
  localparam int DRV_W   = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1,
  localparam int MAX_CNT = (EXEC_LEN > 9) ? EXEC_LEN : 9,
  localparam int IDX_W   = $clog2(MAX_CNT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_acc,
  input  logic             rd_acc,
  input  logic [7:0]       wdata,
  input  op_info_t         dec,
  input  logic             exec_done,
  input  logic [7:0]       media_rdata,
  output logic [7:0]       rdata,
  output logic             rqm,
  output logic             dio,
  output logic             nondma,
  output logic             busy,
  output logic             seek_go,
  output logic [DRV_W-1:0] seek_drv
);
  phase_e             phase_q, phase_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  op_info_t           info_q, info_d;
  logic [7:0]         op_q, op_d;
  logic [DRV_W-1:0]   drv_q, drv_d;
  logic               mode_q, mode_d;
  logic               gap_q, gap_d;
  logic               upd;
  op_info_t           cur;
  logic [IDX_W-1:0]   idx_inc;

  assign cur     = (idx_q == '0) ? dec : info_q;
  assign idx_inc = idx_q + 1'b1;
  assign upd     = wr_acc || rd_acc || exec_done;
  assign gap_d   = wr_acc || rd_acc;

  always_comb begin
    phase_d  = phase_q;
    idx_d    = idx_q;
    info_d   = info_q;
    op_d     = op_q;
    drv_d    = drv_q;
    mode_d   = mode_q;
    seek_go  = 1'b0;
    seek_drv = drv_q;
    unique case (phase_q)
      PH_CMD: if (wr_acc) begin
        if (idx_q == '0) begin
          info_d = dec;
          op_d   = wdata;
          drv_d  = '0;
        end
        if (idx_q == IDX_W'(1)) drv_d = wdata[DRV_W-1:0];
        if (idx_inc == IDX_W'(cur.cmd_len)) begin
          idx_d = '0;
          if (cur.sets_mode) mode_d = wdata[0];
          if (cur.starts_seek) begin
            seek_go  = 1'b1;
            seek_drv = (idx_q == IDX_W'(1)) ? wdata[DRV_W-1:0] : drv_q;
          end
          if (cur.has_exec)              phase_d = PH_EXEC;
          else if (cur.res_len != 3'd0)  phase_d = PH_RES;
        end else begin
          idx_d = idx_inc;
        end
      end
      PH_EXEC: begin
        if (mode_q) begin
          if (wr_acc || rd_acc) begin
            if (idx_inc == IDX_W'(EXEC_LEN)) begin
              idx_d   = '0;
              phase_d = PH_RES;
            end else begin
              idx_d = idx_inc;
            end
          end
        end else if (exec_done) begin
          idx_d   = '0;
          phase_d = PH_RES;
        end
      end
      PH_RES: if (rd_acc) begin
        if (idx_inc == IDX_W'(info_q.res_len)) begin
          idx_d   = '0;
          phase_d = PH_CMD;
        end else begin
          idx_d = idx_inc;
        end
      end
      default: begin
        phase_d = PH_CMD;
        idx_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= 1'b0;
    end else begin
      gap_q <= gap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      idx_q   <= '0;
      info_q  <= '0;
      op_q    <= '0;
      drv_q   <= '0;
      mode_q  <= 1'b0;
    end else if (upd) begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      info_q  <= info_d;
      op_q    <= op_d;
      drv_q   <= drv_d;
      mode_q  <= mode_d;
    end
  end

  assign busy   = (phase_q != PH_CMD) || (idx_q != '0);
  assign rqm    = !gap_q && ((phase_q != PH_EXEC) || mode_q);
  assign dio    = (phase_q == PH_RES) || ((phase_q == PH_EXEC) && info_q.exec_to_host);
  assign nondma = (phase_q == PH_EXEC) && mode_q;

  always_comb begin
    unique case (phase_q)
      PH_RES: begin
        if (idx_q == '0)
          rdata = info_q.known ? {{(8-DRV_W){1'b0}}, drv_q} : BAD_OP_CODE;
        else
          rdata = op_q + 8'(idx_q);
      end
      PH_EXEC: rdata = media_rdata;
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/dskc_phase_seq.sv
module dskc_phase_seq
  import dskc_pkg::*;
#(
  parameter int NUM_DRV  = 2,
  parameter int EXEC_LEN = 4,
  localparam int DRV_W   = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [7:0]         host_wdata,
  output logic [7:0]         host_rdata,
  output logic [7:0]         status,
  input  logic [7:0]         media_rdata,
  input  logic               exec_done,
  input  logic [NUM_DRV-1:0] seek_done
);
  logic               rst_n_s;
  op_info_t           dec;
  logic               rqm, dio, nondma, busy;
  logic               wr_acc, rd_acc;
  logic               seek_go;
  logic [DRV_W-1:0]   seek_drv;
  logic [NUM_DRV-1:0] drv_busy;
  logic [1:0]         drv_bits;

  dskc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  dskc_op_decode u_dec (
    .op_byte (host_wdata),
    .info    (dec)
  );

  assign wr_acc = host_wr && rqm && !dio;
  assign rd_acc = host_rd && rqm && dio;

  dskc_phase_fsm #(
    .NUM_DRV  (NUM_DRV),
    .EXEC_LEN (EXEC_LEN)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .wr_acc      (wr_acc),
    .rd_acc      (rd_acc),
    .wdata       (host_wdata),
    .dec         (dec),
    .exec_done   (exec_done),
    .media_rdata (media_rdata),
    .rdata       (host_rdata),
    .rqm         (rqm),
    .dio         (dio),
    .nondma      (nondma),
    .busy        (busy),
    .seek_go     (seek_go),
    .seek_drv    (seek_drv)
  );

  dskc_drv_busy #(
    .NUM_DRV (NUM_DRV)
  ) u_drv (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .seek_go   (seek_go),
    .seek_drv  (seek_drv),
    .seek_done (seek_done),
    .drv_busy  (drv_busy)
  );

  assign drv_bits = 2'(drv_busy);
  assign status   = {rqm, dio, nondma, busy, 2'b00, drv_bits};
endmodule

// File: rtl/dskc_phase_seq_chk.sv
module dskc_phase_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic       host_rd,
  input logic [7:0] status
);
  logic wr_ok, rd_ok;
  assign wr_ok = host_wr && status[7] && !status[6];
  assign rd_ok = host_rd && status[7] && status[6];

  // R9
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[3:2] == 2'b00);

  // R4
  rqm_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok || rd_ok) |=> !status[7]);

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> $past(wr_ok));

  // R5
  nondma_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] |-> status[4]);

  // R7
  drv0_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> $past(wr_ok));

  // R7
  drv1_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(wr_ok));

  // R10
  idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && status[7] && !status[6]) |=> status[7]);
endmodule

bind dskc_phase_seq dskc_phase_seq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .host_wr (host_wr),
  .host_rd (host_rd),
  .status  (status)
);

// File: tb/sim_dskc_phase_seq.sv
module sim_dskc_phase_seq;
  localparam int CLK_PERIOD = 10;
  localparam int EXEC_LEN   = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_wr, host_rd, exec_done;
  logic [7:0] host_wdata, host_rdata, status, media_rdata;
  logic [1:0] seek_done;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dskc_phase_seq #(.NUM_DRV(2), .EXEC_LEN(EXEC_LEN)) u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .status(status),
    .media_rdata(media_rdata), .exec_done(exec_done), .seek_done(seek_done)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // write one byte; checks the one-clock request gap (R4)
  task automatic wr_byte(input logic [7:0] b);
    host_wdata = b;
    host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    chk("R4 gap after write", {7'b0, status[7]}, 8'h00);
    @(negedge clk);
  endtask

  task automatic rd_byte(input string req, input logic [7:0] exp);
    host_rd = 1'b1;
    #1;
    chk(req, host_rdata, exp);
    @(negedge clk);
    host_rd = 1'b0;
    chk("R4 gap after read", {7'b0, status[7]}, 8'h00);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset status", status, 8'h80);
    chk("R9 reserved zero", {6'b0, status[3:2]}, 8'h00);
  endtask

  task automatic t_mode(input logic polled);
    host_wdata = 8'h03;
    host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    chk("R2 busy after first byte", status, 8'h10);
    @(negedge clk);
    chk("R2 busy mid command", status, 8'h90);
    wr_byte(8'hA5);
    wr_byte({7'h00, polled});
    chk("R2 no-result busy clears", status, 8'h80);
  endtask

  task automatic t_drive_status();
    wr_byte(8'h04);
    wr_byte(8'h01);
    chk("R3 result phase status", status, 8'hD0);
    rd_byte("R3 drive status byte0", 8'h01);
    chk("R3 busy clears after results", status, 8'h80);
  endtask

  task automatic t_int_status();
    wr_byte(8'h08);
    chk("R3 one-byte command to results", status, 8'hD0);
    rd_byte("R3 int status byte0", 8'h00);
    rd_byte("R3 int status byte1", 8'h09);
    chk("R3 int status done", status, 8'h80);
  endtask

  task automatic t_invalid();
    wr_byte(8'h1F);
    chk("R8 invalid to results", status, 8'hD0);
    rd_byte("R8 invalid code", 8'h80);
    chk("R8 invalid done", status, 8'h80);
  endtask

  task automatic t_polled_read();
    t_mode(1'b1);
    wr_byte(8'h46);
    wr_byte(8'h00);
    for (int i = 0; i < 7; i++) wr_byte(8'h10 + 8'(i));
    chk("R5 polled read exec status", status, 8'hF0);
    for (int i = 0; i < EXEC_LEN; i++) begin
      media_rdata = 8'hC0 + 8'(i);
      rd_byte("R5 exec read data", 8'hC0 + 8'(i));
    end
    chk("R5 exec ends in results", status, 8'hD0);
    rd_byte("R3 read result byte0", 8'h00);
    for (int k = 1; k < 7; k++) rd_byte("R3 read result byte", 8'h46 + 8'(k));
    chk("R3 read command done", status, 8'h80);
  endtask

  task automatic t_polled_write();
    wr_byte(8'h45);
    wr_byte(8'h01);
    for (int i = 0; i < 7; i++) wr_byte(8'h20 + 8'(i));
    chk("R5 polled write exec status", status, 8'hB0);
    for (int i = 0; i < EXEC_LEN; i++) wr_byte(8'h55);
    chk("R5 write exec ends", status, 8'hD0);
    rd_byte("R3 write result byte0", 8'h01);
    for (int k = 1; k < 7; k++) rd_byte("R3 write result byte", 8'h45 + 8'(k));
    chk("R3 write command done", status, 8'h80);
  endtask

  task automatic t_dma_read();
    t_mode(1'b0);
    wr_byte(8'hE6);               // modifier bits set, R2 matches low five bits
    wr_byte(8'h01);
    for (int i = 0; i < 7; i++) wr_byte(8'h30);
    chk("R6 DMA exec locked", status, 8'h50);
    repeat (3) @(negedge clk);
    chk("R6 DMA exec holds", status, 8'h50);
    host_rd = 1'b1;               // R10: access while request is 0
    @(negedge clk);
    host_rd = 1'b0;
    chk("R10 access with request low", status, 8'h50);
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
    chk("R6 exec_done to results", status, 8'hD0);
    rd_byte("R6 DMA result byte0", 8'h01);
    for (int k = 1; k < 7; k++) rd_byte("R6 DMA result byte", 8'hE6 + 8'(k));
    chk("R6 DMA command done", status, 8'h80);
  endtask

  task automatic t_ignored();
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    chk("R10 read in write direction", status, 8'h80);
    wr_byte(8'h04);
    wr_byte(8'h01);
    host_wdata = 8'h77;
    host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    chk("R10 write in read direction", status, 8'hD0);
    rd_byte("R10 result unchanged", 8'h01);
    chk("R10 done", status, 8'h80);
  endtask

  task automatic pulse_done(input int d);
    seek_done[d] = 1'b1;
    @(negedge clk);
    seek_done = 2'b00;
  endtask

  task automatic t_overlap_seek();
    wr_byte(8'h0F); wr_byte(8'h00); wr_byte(8'h10);
    chk("R7 drive0 seeking", status, 8'h81);
    wr_byte(8'h0F); wr_byte(8'h01); wr_byte(8'h20);
    chk("R7 both drives seeking", status, 8'h83);
    pulse_done(0);
    chk("R7 drive0 done first", status, 8'h82);
    wr_byte(8'h07); wr_byte(8'h00);
    chk("R7 recalibrate drive0 overlaps", status, 8'h83);
    wr_byte(8'h04);
    chk("R7 command busy independent", status, 8'h93);
    wr_byte(8'h00);
    rd_byte("R7 command during seek", 8'h00);
    pulse_done(1);
    chk("R7 drive1 done", status, 8'h81);
    pulse_done(0);
    chk("R7 all seeks done", status, 8'h80);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    host_wr = 1'b0; host_rd = 1'b0; exec_done = 1'b0;
    host_wdata = 8'h00; media_rdata = 8'h00; seek_done = 2'b00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_mode(1'b0);
    t_drive_status();
    t_int_status();
    t_invalid();
    t_polled_read();
    t_polled_write();
    t_dma_read();
    t_ignored();
    t_overlap_seek();
    t_reset();
    finish_run();
  end
endmodule